// File: doc/BRIEF.md
# 64b/66b Transmit Block Encoder

This block turns one eight-lane transmit word into one 66-bit line block. The input is 64 data bits, with lane 0 in bits 7:0, and one control flag per lane. The output is a 64-bit block payload and a 2-bit sync header.

A word with no control lanes passes through unchanged under the data header. Any other word is sorted into one legal control block format:

- all-control;
- start in lane 0 or lane 4;
- ordered set in lane 0 and/or lane 4, alone or combined with a start;
- terminate in any lane.

Control characters are rewritten as 7-bit line codes. A word that matches no legal layout is replaced by a block made entirely of error codes.

The result is registered. A new block appears one clock after an enabled edge. While the enable is low the output holds. Scrambling and gearboxing are done by later stages.

Top module: `enc66_encoder`

## Requirements
- R1: While reset is asserted, and after it until the first enabled clock, the outputs are header 2'b10 and payload 64'h1E (an all-idle control block).
- R2: When no control flag is set, the block following the enabled edge has header 2'b01 and payload equal to the input word, lane 0 in bits 7:0.
- R3: When any control flag is set, the header is 2'b10. The header is never any value other than 2'b01 or 2'b10.
- R4: A word whose lanes are all control and which matches no other format gives type byte 8'h1E in bits 7:0. The 7-bit code of lane i sits at bits 8+7i. Idle 8'h07 becomes 7'h00, and every other control character (including error 8'hFE) becomes 7'h1E.
- R5: Start 8'hFB in lane 0, with lanes 1 to 7 data, gives type 8'h78 with lanes 1 to 7 in bytes 1 to 7.
- R6: Start in lane 4, with lanes 5 to 7 data, has two forms. If lane 0 is an ordered set followed by three data lanes, the type is 8'h66, its O-code is in bits 35:32 and bits 39:36 are zero. If lanes 0 to 3 are all control, the type is 8'h33, with their 7-bit codes in bits 35:8 and bits 39:36 zero. In both forms lanes 5 to 7 go to bytes 5 to 7, and bytes 1 to 3 of the 8'h66 form carry lanes 1 to 3.
- R7: Ordered sets (sequence 8'h9C gives O-code 4'h0, signal 8'h5C gives O-code 4'hF) have three forms, each with three data lanes after every ordered set:
  - in both lanes 0 and 4: type 8'h55, O-codes at bits 35:32 (lane 0) and 39:36 (lane 4);
  - lane 0 only, with lanes 4 to 7 control: type 8'h4B, lane codes 4 to 7 at bits 36+7(i-4);
  - lane 4 only, with lanes 0 to 3 control: type 8'h2D, lane codes 0 to 3 at bits 35:8.
- R8: Terminate 8'hFD in lane k, with lanes below k data and lanes above k control, gives type 8'h87, 99, AA, B4, CC, D2, E1 or FF for k = 0 to 7. Lanes 0 to k-1 go to bytes 1 to k, the code of each lane i above k sits at bits 8+7i, and all other bits are zero.
- R9: A word with control flags that fits no format above gives header 2'b10 and payload with type 8'h1E and all eight codes 7'h1E.
- R10: While the enable is low, header and payload keep their values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable; one block is encoded per enabled edge |
| txd_i | input | 64 | Transmit word, lane i in bits 8i+7:8i |
| txc_i | input | 8 | Control flag per lane |
| blk_o | output | 64 | Encoded block payload, type byte in bits 7:0 |
| hdr_o | output | 2 | Sync header: 2'b01 data, 2'b10 control |

## Verification
The bench targets the places where block formats neighbour each other:
- A start in lane 4 with an ordered set versus control in lanes 0 to 3. An encoder that mixes them up emits 8'h33 where 8'h66 belongs, or the reverse.
- A terminate at lane 0 and at lane 7, where the payload is nearly all codes or nearly all data. An off-by-one in the packing shifts bytes into code fields.
- Near-legal words: a stray control lane after a start, a terminate followed by data, a start in an unsupported lane. A permissive encoder would send these as a valid block instead of the all-error block.
- Disabled cycles with changing inputs, which expose an encoder that updates without the enable.

// File: rtl/enc66_pkg.sv
package enc66_pkg;
  localparam int LANES   = 8;
  localparam int BYTE_W  = 8;
  localparam int CODE_W  = 7;
  localparam int OCODE_W = 4;
  localparam int BLK_W   = LANES * BYTE_W;
  localparam int CODES_W = LANES * CODE_W;

  localparam logic [1:0] SYNC_DATA = 2'b01;
  localparam logic [1:0] SYNC_CTRL = 2'b10;

  // lane characters
  localparam logic [7:0] XC_IDLE  = 8'h07;
  localparam logic [7:0] XC_START = 8'hFB;
  localparam logic [7:0] XC_TERM  = 8'hFD;
  localparam logic [7:0] XC_SEQ   = 8'h9C;
  localparam logic [7:0] XC_SIG   = 8'h5C;

  // line codes
  localparam logic [CODE_W-1:0]  LC_IDLE  = 7'h00;
  localparam logic [CODE_W-1:0]  LC_ERROR = 7'h1E;
  localparam logic [OCODE_W-1:0] OC_SEQ   = 4'h0;
  localparam logic [OCODE_W-1:0] OC_SIG   = 4'hF;

  // block types
  localparam logic [7:0] BT_CTRL   = 8'h1E;
  localparam logic [7:0] BT_S0     = 8'h78;
  localparam logic [7:0] BT_S4     = 8'h33;
  localparam logic [7:0] BT_OS_S4  = 8'h66;
  localparam logic [7:0] BT_OS_OS  = 8'h55;
  localparam logic [7:0] BT_OS0    = 8'h4B;
  localparam logic [7:0] BT_OS4    = 8'h2D;

  function automatic logic [7:0] term_type(input int k);
    case (k)
      0:       return 8'h87;
      1:       return 8'h99;
      2:       return 8'hAA;
      3:       return 8'hB4;
      4:       return 8'hCC;
      5:       return 8'hD2;
      6:       return 8'hE1;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] map_code(input logic [7:0] ch);
    return (ch == XC_IDLE) ? LC_IDLE : LC_ERROR;
  endfunction
endpackage

// File: rtl/enc66_lane_class.sv
module enc66_lane_class
  import enc66_pkg::*;
#(
  parameter int NL = LANES
) (
  input  logic [NL*BYTE_W-1:0]            d_i,
  input  logic [NL-1:0]                   c_i,
  output logic [NL-1:0]                   start_o,
  output logic [NL-1:0]                   term_o,
  output logic [NL-1:0]                   os_o,
  output logic [NL-1:0][OCODE_W-1:0]      ocode_o,
  output logic [NL-1:0][CODE_W-1:0]       code_o
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [BYTE_W-1:0] ch;
    assign ch         = d_i[l*BYTE_W +: BYTE_W];
    assign start_o[l] = c_i[l] && (ch == XC_START);
    assign term_o[l]  = c_i[l] && (ch == XC_TERM);
    assign os_o[l]    = c_i[l] && ((ch == XC_SEQ) || (ch == XC_SIG));
    assign ocode_o[l] = (ch == XC_SIG) ? OC_SIG : OC_SEQ;
    assign code_o[l]  = map_code(ch);
  end
endmodule

// File: rtl/enc66_term_pack.sv
module enc66_term_pack
  import enc66_pkg::*;
#(
  parameter int NL = LANES
) (
  input  logic [(NL-1)*BYTE_W-1:0]        d_i,
  input  logic [NL-1:0]                   c_i,
  input  logic [NL-1:0]                   term_i,
  input  logic [NL-1:1][CODE_W-1:0]       code_i,
  output logic [NL-1:0]                   hit_o,
  output logic [NL-1:0][NL*BYTE_W-1:0]    blk_o
);
  // one candidate block per terminate position
  for (genvar k = 0; k < NL; k++) begin : g_term
    logic                 hit;
    logic [NL*BYTE_W-1:0] blk;
    always_comb begin
      hit       = term_i[k];
      blk       = '0;
      blk[7:0]  = term_type(k);
      for (int i = 0; i < NL - 1; i++) begin
        if (i < k) begin
          hit = hit & ~c_i[i];
          blk[BYTE_W*(i+1) +: BYTE_W] = d_i[BYTE_W*i +: BYTE_W];
        end
      end
      for (int i = 1; i < NL; i++) begin
        if (i > k) begin
          hit = hit & c_i[i];
          blk[8 + CODE_W*i +: CODE_W] = code_i[i];
        end
      end
    end
    assign hit_o[k] = hit;
    assign blk_o[k] = blk;
  end
endmodule

// File: rtl/enc66_block_sel.sv
module enc66_block_sel
  import enc66_pkg::*;
(
  input  logic [BLK_W-1:0]               d_i,
  input  logic [LANES-1:0]               c_i,
  input  logic                           start0_i,
  input  logic                           start4_i,
  input  logic                           os0_i,
  input  logic                           os4_i,
  input  logic [OCODE_W-1:0]             ocode0_i,
  input  logic [OCODE_W-1:0]             ocode4_i,
  input  logic [LANES-1:0][CODE_W-1:0]   code_i,
  input  logic [LANES-1:0]               term_hit_i,
  input  logic [LANES-1:0][BLK_W-1:0]    term_blk_i,
  output logic [1:0]                     hdr_o,
  output logic [BLK_W-1:0]               blk_o
);
  logic s0_hit, s4_base, os0_dat, os4_dat;
  logic ossa_hit, s4_hit, osos_hit, os0_hit, os4_hit;

  assign s0_hit   = start0_i && (c_i[7:1] == '0);
  assign s4_base  = start4_i && (c_i[7:5] == '0);
  assign os0_dat  = os0_i && (c_i[3:1] == '0);
  assign os4_dat  = os4_i && (c_i[7:5] == '0);
  assign ossa_hit = s4_base && os0_dat;
  assign s4_hit   = s4_base && !os0_dat && (&c_i[3:0]);
  assign osos_hit = os0_dat && os4_dat;
  assign os0_hit  = os0_dat && !os4_dat && (&c_i[7:4]);
  assign os4_hit  = os4_dat && !os0_dat && (&c_i[3:0]);

  always_comb begin
    hdr_o = SYNC_CTRL;
    blk_o = {{LANES{LC_ERROR}}, BT_CTRL};
    if (c_i == '0) begin
      hdr_o = SYNC_DATA;
      blk_o = d_i;
    end else if (s0_hit) begin
      blk_o = {d_i[63:8], BT_S0};
    end else if (ossa_hit) begin
      blk_o = {d_i[63:40], 4'h0, ocode0_i, d_i[31:8], BT_OS_S4};
    end else if (s4_hit) begin
      blk_o = {d_i[63:40], 4'h0, code_i[3:0], BT_S4};
    end else if (osos_hit) begin
      blk_o = {d_i[63:40], ocode4_i, ocode0_i, d_i[31:8], BT_OS_OS};
    end else if (os0_hit) begin
      blk_o = {code_i[7:4], ocode0_i, d_i[31:8], BT_OS0};
    end else if (os4_hit) begin
      blk_o = {d_i[63:40], ocode4_i, code_i[3:0], BT_OS4};
    end else if (|term_hit_i) begin
      for (int k = 0; k < LANES; k++) begin
        if (term_hit_i[k]) blk_o = term_blk_i[k];
      end
    end else if (&c_i) begin
      blk_o = {code_i, BT_CTRL};
    end
  end
endmodule

// File: rtl/enc66_encoder.sv
module enc66_encoder
  import enc66_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [BLK_W-1:0] txd_i,
  input  logic [LANES-1:0] txc_i,
  output logic [BLK_W-1:0] blk_o,
  output logic [1:0]       hdr_o
);
  logic [LANES-1:0]              start_v, term_v, os_v;
  logic [LANES-1:0][OCODE_W-1:0] ocode_v;
  logic [LANES-1:0][CODE_W-1:0]  code_v;
  logic [LANES-1:0]              term_hit;
  logic [LANES-1:0][BLK_W-1:0]   term_blk;
  logic [1:0]                    hdr_d;
  logic [BLK_W-1:0]              blk_d;
  logic                          unused_cls;

  assign unused_cls = ^{start_v[7:5], start_v[3:1], os_v[7:5], os_v[3:1],
                        ocode_v[7:5], ocode_v[3:1]};

  enc66_lane_class #(.NL(LANES)) u_class (
    .d_i     (txd_i),
    .c_i     (txc_i),
    .start_o (start_v),
    .term_o  (term_v),
    .os_o    (os_v),
    .ocode_o (ocode_v),
    .code_o  (code_v)
  );

  enc66_term_pack #(.NL(LANES)) u_term (
    .d_i    (txd_i[(LANES-1)*BYTE_W-1:0]),
    .c_i    (txc_i),
    .term_i (term_v),
    .code_i (code_v[LANES-1:1]),
    .hit_o  (term_hit),
    .blk_o  (term_blk)
  );

  enc66_block_sel u_sel (
    .d_i        (txd_i),
    .c_i        (txc_i),
    .start0_i   (start_v[0]),
    .start4_i   (start_v[4]),
    .os0_i      (os_v[0]),
    .os4_i      (os_v[4]),
    .ocode0_i   (ocode_v[0]),
    .ocode4_i   (ocode_v[4]),
    .code_i     (code_v),
    .term_hit_i (term_hit),
    .term_blk_i (term_blk),
    .hdr_o      (hdr_d),
    .blk_o      (blk_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_o <= SYNC_CTRL;
      blk_o <= {{(BLK_W-8){1'b0}}, BT_CTRL};
    end else if (en_i) begin
      hdr_o <= hdr_d;
      blk_o <= blk_d;
    end
  end

  p_data_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && txc_i == '0) |=> (hdr_o == SYNC_DATA && blk_o == $past(txd_i)));

  p_ctrl_hdr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && txc_i != '0) |=> (hdr_o == SYNC_CTRL));

  p_hdr_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_o == SYNC_DATA) || (hdr_o == SYNC_CTRL));

  p_err_chars_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (&txc_i) && txd_i == {LANES{8'hFE}})
    |=> (blk_o == {{LANES{LC_ERROR}}, BT_CTRL}));

  p_start0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && txc_i == 8'h01 && txd_i[7:0] == XC_START)
    |=> (blk_o[7:0] == BT_S0 && blk_o[63:8] == $past(txd_i[63:8])));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(hdr_o) && $stable(blk_o)));
endmodule

// File: tb/tb_enc66_encoder.sv
module tb_enc66_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [63:0] txd = '0;
  logic [7:0]  txc = '0;
  logic [63:0] blk;
  logic [1:0]  hdr;

  int          total = 0;
  int          bad = 0;
  logic [1:0]  exp_h = 2'b10;
  logic [63:0] exp_b = 64'h1E;
  string       exp_tag = "R1";

  always #4 clk = ~clk;

  enc66_encoder dut (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en),
    .txd_i (txd), .txc_i (txc), .blk_o (blk), .hdr_o (hdr)
  );

  function automatic logic [7:0] lb(input logic [63:0] d, input int l);
    return d[8*l +: 8];
  endfunction
  function automatic logic [6:0] rc(input logic [7:0] ch);
    return (ch == 8'h07) ? 7'h00 : 7'h1E;
  endfunction
  function automatic bit is_ch(input logic [63:0] d, input logic [7:0] c, input int l, input logic [7:0] ch);
    return c[l] && lb(d, l) == ch;
  endfunction
  function automatic bit is_os(input logic [63:0] d, input logic [7:0] c, input int l);
    return is_ch(d, c, l, 8'h9C) || is_ch(d, c, l, 8'h5C);
  endfunction
  function automatic bit all_d(input logic [7:0] c, input int lo, input int hi);
    for (int l = lo; l <= hi; l++) if (c[l]) return 0;
    return 1;
  endfunction
  function automatic bit all_c(input logic [7:0] c, input int lo, input int hi);
    for (int l = lo; l <= hi; l++) if (!c[l]) return 0;
    return 1;
  endfunction
  function automatic logic [3:0] oc(input logic [7:0] ch);
    return (ch == 8'h5C) ? 4'hF : 4'h0;
  endfunction

  // behavioural reference of one block
  task automatic ref_enc(input logic [63:0] d, input logic [7:0] c,
                         output logic [1:0] h, output logic [63:0] b, output string tag);
    int tk;
    logic [7:0] tt [8];
    tt = '{8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};
    h = 2'b10; b = '0; tk = -1;
    for (int k = 0; k < 8; k++)
      if (is_ch(d, c, k, 8'hFD) && (k == 0 || all_d(c, 0, k-1)) && (k == 7 || all_c(c, k+1, 7))) tk = k;
    if (c == 8'h00) begin
      h = 2'b01; b = d; tag = "R2";
    end else if (is_ch(d, c, 0, 8'hFB) && all_d(c, 1, 7)) begin
      b = d; b[7:0] = 8'h78; tag = "R5";
    end else if (is_ch(d, c, 4, 8'hFB) && all_d(c, 5, 7) && is_os(d, c, 0) && all_d(c, 1, 3)) begin
      b = d; b[7:0] = 8'h66; b[39:32] = {4'h0, oc(lb(d, 0))}; tag = "R6";
    end else if (is_ch(d, c, 4, 8'hFB) && all_d(c, 5, 7) && all_c(c, 0, 3)) begin
      b = d; b[39:0] = 40'h0; b[7:0] = 8'h33;
      for (int l = 0; l < 4; l++) b[8+7*l +: 7] = rc(lb(d, l));
      tag = "R6";
    end else if (is_os(d, c, 0) && all_d(c, 1, 3) && is_os(d, c, 4) && all_d(c, 5, 7)) begin
      b = d; b[7:0] = 8'h55; b[39:32] = {oc(lb(d, 4)), oc(lb(d, 0))}; tag = "R7";
    end else if (is_os(d, c, 0) && all_d(c, 1, 3) && all_c(c, 4, 7)) begin
      b[31:0] = {d[31:8], 8'h4B}; b[35:32] = oc(lb(d, 0));
      for (int l = 4; l < 8; l++) b[36+7*(l-4) +: 7] = rc(lb(d, l));
      tag = "R7";
    end else if (is_os(d, c, 4) && all_d(c, 5, 7) && all_c(c, 0, 3)) begin
      b = d; b[7:0] = 8'h2D; b[39:36] = oc(lb(d, 4));
      for (int l = 0; l < 4; l++) b[8+7*l +: 7] = rc(lb(d, l));
      tag = "R7";
    end else if (tk >= 0) begin
      b[7:0] = tt[tk];
      for (int l = 0; l < tk; l++) b[8*(l+1) +: 8] = lb(d, l);
      for (int l = tk + 1; l < 8; l++) b[8+7*l +: 7] = rc(lb(d, l));
      tag = "R8";
    end else if (c == 8'hFF) begin
      b[7:0] = 8'h1E;
      for (int l = 0; l < 8; l++) b[8+7*l +: 7] = rc(lb(d, l));
      tag = "R4";
    end else begin
      b = {{8{7'h1E}}, 8'h1E}; tag = "R9";
    end
  endtask

  task automatic check_out();
    total++;
    if (hdr !== exp_h || blk !== exp_b) begin
      bad++;
      $display("FAIL %s: hdr=%b blk=%h expected hdr=%b blk=%h", exp_tag, hdr, blk, exp_h, exp_b);
    end
  endtask

  task automatic step(input logic [63:0] d, input logic [7:0] c, input bit e);
    @(negedge clk);
    check_out();
    txd = d; txc = c; en = e;
    if (e) ref_enc(d, c, exp_h, exp_b, exp_tag);
    else exp_tag = "R10";
  endtask

  function automatic logic [7:0] rctl();
    case ($urandom % 9)
      0, 1, 2: return 8'h07;
      3:       return 8'hFE;
      4:       return 8'h06;
      5:       return 8'hFB;
      6:       return 8'hFD;
      7:       return 8'h9C;
      default: return 8'h5C;
    endcase
  endfunction
  function automatic logic [7:0] ros();
    return ($urandom % 2) ? 8'h9C : 8'h5C;
  endfunction

  task automatic gen(output logic [63:0] d, output logic [7:0] c);
    int k;
    d = {$urandom, $urandom}; c = '0;
    case ($urandom % 10)
      1: begin c = 8'hFF; for (int l = 0; l < 8; l++) d[8*l +: 8] = rctl(); end
      2: begin c = 8'h01; d[7:0] = 8'hFB; end
      3: begin c = 8'h1F; d[39:32] = 8'hFB; for (int l = 0; l < 4; l++) d[8*l +: 8] = rctl(); end
      4: begin c = 8'h11; d[7:0] = ros(); d[39:32] = 8'hFB; end
      5: begin c = 8'h11; d[7:0] = ros(); d[39:32] = ros(); end
      6: begin c = 8'hF1; d[7:0] = ros(); for (int l = 4; l < 8; l++) d[8*l +: 8] = rctl(); end
      7: begin c = 8'h1F; d[39:32] = ros(); for (int l = 0; l < 4; l++) d[8*l +: 8] = rctl(); end
      8: begin
        k = $urandom % 8; c = 8'hFF << k; d[8*k +: 8] = 8'hFD;
        for (int l = k + 1; l < 8; l++) d[8*l +: 8] = rctl();
      end
      9: begin c = 8'($urandom); for (int l = 0; l < 8; l++) if (c[l]) d[8*l +: 8] = rctl(); end
      default: ;
    endcase
  endtask

  initial begin
    #(64'd8 * 200000);
    total++; bad++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [7:0]  c;
    repeat (3) @(negedge clk);
    check_out();                       // R1 during reset
    rst_n = 1'b1;
    step(64'h0123_4567_89AB_CDEF, 8'h00, 1'b1);        // R1 check, then R2
    step({8{8'h07}}, 8'hFF, 1'b1);                     // R4 idle
    step(64'h07FE_0607_FE07_0607, 8'hFF, 1'b1);        // R4 mixed codes
    step(64'hD555_5555_5555_55FB, 8'h01, 1'b1);        // R5
    step(64'hA1B2_C3FB_0707_0707, 8'h1F, 1'b1);        // R6 0x33
    step(64'h1122_33FB_4455_669C, 8'h11, 1'b1);        // R6 0x66 seq
    step(64'h1122_33FB_4455_665C, 8'h11, 1'b1);        // R6 0x66 sig
    step(64'h8899_AA9C_BBCC_DD5C, 8'h11, 1'b1);        // R7 0x55
    step(64'h0707_0707_1122_335C, 8'hF1, 1'b1);        // R7 0x4B
    step(64'h1122_335C_07FE_0707, 8'h1F, 1'b1);        // R7 0x2D
    for (int k = 0; k < 8; k++) begin                  // R8 each lane
      d = '0;
      for (int l = 0; l < 8; l++)
        d[8*l +: 8] = (l < k) ? 8'(8'h10 + l) : (l == k) ? 8'hFD : (l == 7 ? 8'hFE : 8'h07);
      step(d, 8'hFF << k, 1'b1);
    end
    step(64'h5555_5555_0755_55FB, 8'h09, 1'b1);        // R9 stray control after start
    step(64'h5555_5555_55FB_0707, 8'h07, 1'b1);        // R9 start in lane 2
    step(64'h5555_55FB_1122_3344, 8'h10, 1'b1);        // R9 data under lane-4 start
    step(64'h0707_5507_FD55_5555, 8'hD8, 1'b1);        // R9 data after terminate
    step(64'h5555_0707_1122_339C, 8'h31, 1'b1);        // R9 ordered set with mixed tail
    step(64'hDEAD_BEEF_0000_0001, 8'h00, 1'b0);        // R10 hold
    step({8{8'hFE}}, 8'hFF, 1'b0);                     // R10 hold
    step(64'hD555_5555_5555_55FB, 8'h01, 1'b0);        // R10 hold
    step(64'h0123_4567_89AB_CDEF, 8'h00, 1'b1);
    for (int n = 0; n < 3000; n++) begin
      gen(d, c);
      step(d, c, ($urandom % 8) != 0);
    end
    step('0, '0, 1'b0);
    step('0, '0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule